// File: doc/BRIEF.md
# Serial Transceiver with Internal Loopback Diagnostics

This block is a byte-wide asynchronous serial transmitter and receiver. A register-style host bus reaches a transmit holding register, a receive buffer, an interrupt enable register, a line status register, a line control register, a modem control register, a modem status register and a pair of divisor latches. A baud generator divides the system clock by a 16-bit divisor to make a tick at sixteen times the bit rate. Both the transmitter and the receiver step on that tick.

For board-level self-test, one modem control bit switches the block into an internal loopback. The serial output pin is then parked at the mark level and the receive pin is ignored. The transmitter drives the receiver directly. The four modem control outputs are forced inactive at the pins and are fed back into the four modem status inputs. Receive-ready, transmit-empty and modem-change interrupts keep working in this mode, so host software can run a full transfer and interrupt check without any external wiring. All modem pins and status inputs are active high.

Top module: `lbk_uart`

## Requirements
- R1: Offsets 0 and 1 reach the divisor low and high bytes only while line control bit 7 is set. Otherwise a write to offset 0 loads the transmit holding register, a read of offset 0 returns the receive buffer, and offset 1 is the interrupt enable register. Offset 3 is line control and reads back as written.
- R2: The bit period is 16 times the divisor in clock cycles. With a 1.8432 MHz clock, divisors 3, 2 and 1 give 38400, 57600 and 115200 bit/s. A divisor of 0 stops the tick.
- R3: A frame on the serial output is one low start bit, eight data bits least significant first, and one high stop bit. The line idles high.
- R4: The receiver checks the start bit at the 8th tick after it sees the line low. If the line is high there, it returns to idle and delivers nothing. A received byte sets line status bit 0, and a read of the receive buffer clears it.
- R5: While modem control bit 4 is set, the serial output pin stays high, the serial input pin is ignored, and transmitted frames arrive in the receive buffer.
- R6: Outside loopback, modem control bits 0 to 3 drive the pins dtr_o, rts_o, out1_o and out2_o in that order. In loopback all four pins are held low.
- R7: Modem status bits 7 to 4 report carrier detect, ring, data-set-ready and clear-to-send. In loopback these come from modem control bit 3, bit 2, bit 0 and bit 1 respectively.
- R8: Modem status bits 3 to 0 are change flags for the same four signals in the same order. Each flag is set when its signal changes and is cleared when modem status is read.
- R9: irq is high when interrupt enable bit 0 is set and data is ready, or bit 1 is set and the holding register is empty, or bit 2 is set and any change flag is set. This also holds in loopback.
- R10: Line status bit 0 means data ready, bit 1 means holding register empty, bit 2 means transmitter fully idle, and bit 3 means the last received stop bit was low. After reset line status reads 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read side effects occur at its edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| ser_tx | output | 1 | Serial output pin |
| ser_rx | input | 1 | Serial input pin |
| cts_i | input | 1 | Clear-to-send status input |
| dsr_i | input | 1 | Data-set-ready status input |
| dcd_i | input | 1 | Carrier-detect status input |
| ri_i | input | 1 | Ring-indicator status input |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |

## Verification
The bench holds the serial input at break level while loopback is active. A design that fails to isolate the pin would then report a spurious byte, or corrupt the looped one. It sets the external status inputs to a pattern that differs from the modem control bits, so that a swapped cross-connection, such as carrier taken from out1 or clear-to-send taken from dtr, shows up as a wrong status bit and a wrong change flag. It measures the start-plus-zero-data low time at three divisors, which exposes an off-by-one tick period or a transmitter that starts off the tick. It sends a short low glitch to test false-start rejection, and it sends a frame with a low stop bit to test the framing flag.

// File: rtl/lbk_uart_pkg.sv
package lbk_uart_pkg;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
   localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
   localparam logic [ADDR_W-1:0] A_LSTAT = 3'd2;
   localparam logic [ADDR_W-1:0] A_LCTRL = 3'd3;
   localparam logic [ADDR_W-1:0] A_MCTRL = 3'd4;
   localparam logic [ADDR_W-1:0] A_MSTAT = 3'd5;

   // modem control, bit 4 down to bit 0
   typedef struct packed {
      logic loop;
      logic out2;
      logic out1;
      logic rts;
      logic dtr;
   } mctrl_t;

   // modem status signals, bit 3 down to bit 0
   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mstat_t;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/lbk_baud_gen.sv
module lbk_baud_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             div_zero;

   assign div_zero = (divisor == '0);
   // >= lets a shrinking divisor recover without waiting for a wrap
   assign tick     = !div_zero && (cnt >= (divisor - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (div_zero || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/lbk_tx.sv
module lbk_tx #(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 wr_en,
   input  logic [DATA_BITS-1:0] wr_data,
   output logic                 hold_empty,
   output logic                 idle,
   output logic                 txd
);

   localparam int unsigned FRAME = DATA_BITS + 2;
   localparam int unsigned CNT_W = $clog2(OVS);
   localparam int unsigned BIT_W = $clog2(FRAME);

   logic [DATA_BITS-1:0] hold;
   logic                 hold_full;
   logic [FRAME-1:0]     shreg;
   logic                 busy;
   logic [CNT_W-1:0]     tcnt;
   logic [BIT_W-1:0]     bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         shreg     <= '1;
         busy      <= 1'b0;
         tcnt      <= '0;
         bcnt      <= '0;
      end else begin
         if (!busy) begin
            // frames start on a tick so every bit spans exactly OVS ticks
            if (hold_full && tick) begin
               shreg     <= {1'b1, hold, 1'b0};
               busy      <= 1'b1;
               tcnt      <= '0;
               bcnt      <= '0;
               hold_full <= 1'b0;
            end
         end else if (tick) begin
            if (tcnt == CNT_W'(OVS - 1)) begin
               tcnt  <= '0;
               shreg <= {1'b1, shreg[FRAME-1:1]};
               if (bcnt == BIT_W'(FRAME - 1)) begin
                  busy <= 1'b0;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
         if (wr_en) begin
            hold      <= wr_data;
            hold_full <= 1'b1;
         end
      end
   end

   assign txd        = busy ? shreg[0] : 1'b1;
   assign hold_empty = !hold_full;
   assign idle       = !hold_full && !busy;

endmodule

// File: rtl/lbk_rx.sv
module lbk_rx
   import lbk_uart_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned OVS       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   input  logic                 rd_ack,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_ready,
   output logic                 frame_err
);

   localparam int unsigned CNT_W = $clog2(OVS);
   localparam int unsigned BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   // detection tick is sample 1, so mid-bit sample OVS/2 is OVS/2-1 ticks later
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 2);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

   rx_state_e            state;
   logic [CNT_W-1:0]     tcnt;
   logic [BIT_W-1:0]     bcnt;
   logic [DATA_BITS-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         tcnt      <= '0;
         bcnt      <= '0;
         shreg     <= '0;
         rx_data   <= '0;
         rx_ready  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         if (rd_ack) begin
            rx_ready <= 1'b0;
         end
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rxd) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt == MID_CNT) begin
                     tcnt <= '0;
                     bcnt <= '0;
                     state <= rxd ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tcnt == LAST_CNT) begin
                     tcnt  <= '0;
                     shreg <= {rxd, shreg[DATA_BITS-1:1]};
                     if (bcnt == BIT_W'(DATA_BITS - 1)) begin
                        state <= RX_STOP;
                     end else begin
                        bcnt <= bcnt + 1'b1;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tcnt == LAST_CNT) begin
                     tcnt      <= '0;
                     state     <= RX_IDLE;
                     rx_data   <= shreg;
                     rx_ready  <= 1'b1;
                     frame_err <= !rxd;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/lbk_modem.sv
module lbk_modem
   import lbk_uart_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  mctrl_t mctrl,
   input  mstat_t ext_stat,
   input  logic   stat_rd,
   output mstat_t stat_q,
   output mstat_t delta,
   output logic   rts_o,
   output logic   dtr_o,
   output logic   out1_o,
   output logic   out2_o
);

   mstat_t eff;

   always_comb begin
      if (mctrl.loop) begin
         eff.cts = mctrl.rts;
         eff.dsr = mctrl.dtr;
         eff.dcd = mctrl.out2;
         eff.ri  = mctrl.out1;
      end else begin
         eff = ext_stat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         delta  <= '0;
      end else begin
         stat_q <= eff;
         // a change in the read cycle survives the clear
         delta  <= (stat_rd ? mstat_t'('0) : delta) | (eff ^ stat_q);
      end
   end

   assign rts_o  = mctrl.rts  && !mctrl.loop;
   assign dtr_o  = mctrl.dtr  && !mctrl.loop;
   assign out1_o = mctrl.out1 && !mctrl.loop;
   assign out2_o = mctrl.out2 && !mctrl.loop;

endmodule

// File: rtl/lbk_uart.sv
module lbk_uart
   import lbk_uart_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq,
   output logic       ser_tx,
   input  logic       ser_rx,
   input  logic       cts_i,
   input  logic       dsr_i,
   input  logic       dcd_i,
   input  logic       ri_i,
   output logic       rts_o,
   output logic       dtr_o,
   output logic       out1_o,
   output logic       out2_o
);

   localparam int unsigned SYNC_W   = 5;
   localparam logic [SYNC_W-1:0] SYNC_RST = 5'b1_0000;
   localparam int unsigned IEN_W    = 3;

   // elaboration-time parameter checks
   if (DATA_BITS != 8) begin : g_bad_data
      $error("lbk_uart: DATA_BITS must match the 8-bit host bus");
   end
   if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
      $error("lbk_uart: DIV_W must lie in 9..16");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("lbk_uart: OVS must be even and at least 4");
   end

   // ---------------- registers ----------------
   logic [7:0]       lctrl;
   logic [IEN_W-1:0] ien;
   mctrl_t           mctrl;
   logic [7:0]       div_lo;
   logic [7:0]       div_hi;
   logic             latch_sel;
   logic [15:0]      div_full;
   logic [DIV_W-1:0] divisor;

   assign latch_sel = lctrl[7];
   assign div_full  = {div_hi, div_lo};
   assign divisor   = div_full[DIV_W-1:0];

   logic wr_thr, rd_rbr, rd_msr;
   assign wr_thr = bus_wr && (bus_addr == A_DATA) && !latch_sel;
   assign rd_rbr = bus_rd && (bus_addr == A_DATA) && !latch_sel;
   assign rd_msr = bus_rd && (bus_addr == A_MSTAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctrl  <= '0;
         ien    <= '0;
         mctrl  <= '0;
         div_lo <= '0;
         div_hi <= '0;
      end else if (bus_wr) begin
         unique case (bus_addr)
            A_DATA:  if (latch_sel) div_lo <= bus_wdata;
            A_IEN:   if (latch_sel) div_hi <= bus_wdata;
                     else ien <= bus_wdata[IEN_W-1:0];
            A_LCTRL: lctrl <= bus_wdata;
            A_MCTRL: mctrl <= mctrl_t'(bus_wdata[4:0]);
            default: ;
         endcase
      end
   end

   // ---------------- input synchronisers ----------------
   logic [SYNC_W-1:0] sync_in, sync_out;
   assign sync_in = {ser_rx, dcd_i, ri_i, dsr_i, cts_i};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sync_out = sync_in;
      end else begin : g_sync
         logic [SYNC_W-1:0] stage [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage[s] <= SYNC_RST;
               end else if (s == 0) begin
                  stage[s] <= sync_in;
               end else begin
                  stage[s] <= stage[(s == 0) ? 0 : s - 1];
               end
            end
         end
         assign sync_out = stage[SYNC_STAGES-1];
      end
   endgenerate

   // ---------------- datapath ----------------
   logic baud_tick;
   logic tx_line, rx_line;
   logic hold_empty, tx_idle;
   logic [DATA_BITS-1:0] rx_data;
   logic rx_ready, frame_err;

   lbk_baud_gen #(
      .DIV_W (DIV_W)
   ) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (baud_tick)
   );

   lbk_tx #(
      .DATA_BITS (DATA_BITS),
      .OVS       (OVS)
   ) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .wr_en      (wr_thr),
      .wr_data    (bus_wdata),
      .hold_empty (hold_empty),
      .idle       (tx_idle),
      .txd        (tx_line)
   );

   assign rx_line = mctrl.loop ? tx_line : sync_out[4];
   assign ser_tx  = mctrl.loop ? 1'b1 : tx_line;

   lbk_rx #(
      .DATA_BITS (DATA_BITS),
      .OVS       (OVS)
   ) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .rxd       (rx_line),
      .rd_ack    (rd_rbr),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .frame_err (frame_err)
   );

   mstat_t stat_q, delta;

   lbk_modem i_modem (
      .clk      (clk),
      .rst_n    (rst_n),
      .mctrl    (mctrl),
      .ext_stat (mstat_t'(sync_out[3:0])),
      .stat_rd  (rd_msr),
      .stat_q   (stat_q),
      .delta    (delta),
      .rts_o    (rts_o),
      .dtr_o    (dtr_o),
      .out1_o   (out1_o),
      .out2_o   (out2_o)
   );

   // ---------------- interrupt and read mux ----------------
   assign irq = (ien[0] && rx_ready) || (ien[1] && hold_empty) || (ien[2] && (delta != '0));

   always_comb begin
      unique case (bus_addr)
         A_DATA:  bus_rdata = latch_sel ? div_lo : rx_data;
         A_IEN:   bus_rdata = latch_sel ? div_hi : {5'b0, ien};
         A_LSTAT: bus_rdata = {4'b0, frame_err, tx_idle, hold_empty, rx_ready};
         A_LCTRL: bus_rdata = lctrl;
         A_MCTRL: bus_rdata = {3'b0, mctrl};
         A_MSTAT: bus_rdata = {stat_q, delta};
         default: bus_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/lbk_uart_chk.sv
module lbk_uart_chk
   import lbk_uart_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input mctrl_t           mctrl,
   input logic             ser_tx,
   input logic [3:0]       pins,
   input logic             tick,
   input logic [DIV_W-1:0] divisor,
   input logic             wr_thr,
   input logic             hold_empty,
   input logic [3:0]       stat_q,
   input logic [3:0]       delta,
   input logic             ien_mod,
   input logic             irq
);

   assert_no_tick_zero_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) |-> !tick);

   assert_thr_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_thr |=> !hold_empty);

   assert_tx_pin_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mctrl.loop |-> ser_tx);

   assert_pins_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mctrl.loop |-> (pins == 4'b0000));

   assert_delta_follows_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q ^ $past(stat_q)) != 4'b0) |-> ((delta & (stat_q ^ $past(stat_q))) == (stat_q ^ $past(stat_q))));

   assert_modem_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_mod && ((stat_q ^ $past(stat_q)) != 4'b0)) |-> irq);

endmodule

bind lbk_uart lbk_uart_chk #(
   .DIV_W (DIV_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mctrl      (mctrl),
   .ser_tx     (ser_tx),
   .pins       ({out2_o, out1_o, rts_o, dtr_o}),
   .tick       (baud_tick),
   .divisor    (divisor),
   .wr_thr     (wr_thr),
   .hold_empty (hold_empty),
   .stat_q     (stat_q),
   .delta      (delta),
   .ien_mod    (ien[2]),
   .irq        (irq)
);

// File: tb/test_lbk_uart.sv
module test_lbk_uart;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       irq, ser_tx;
   logic       ser_rx = 1'b1;
   logic [3:0] ext = 4'b0000;   // {dcd, ri, dsr, cts}
   logic       rts_o, dtr_o, out1_o, out2_o;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   logic [4:0] m_mcr = '0;
   logic [3:0] m_eff = '0, m_delta = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lbk_uart i_lbk_uart (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq),
      .ser_tx (ser_tx), .ser_rx (ser_rx),
      .cts_i (ext[0]), .dsr_i (ext[1]), .ri_i (ext[2]), .dcd_i (ext[3]),
      .rts_o (rts_o), .dtr_o (dtr_o), .out1_o (out1_o), .out2_o (out2_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   // per-clock reference comparison of pins, R5 and R6
   always @(posedge clk) begin
      #(CLK_PERIOD / 4);
      if (rst_n) begin
         check("R6 pins", {out2_o, out1_o, rts_o, dtr_o},
               m_mcr[4] ? 4'b0000 : m_mcr[3:0]);
         if (m_mcr[4]) check("R5 tx mark", ser_tx, 1'b1);
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   function automatic logic [3:0] eff_of(input logic [4:0] mc, input logic [3:0] e);
      return mc[4] ? {mc[3], mc[2], mc[0], mc[1]} : e;
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1;
      if (a == 3'd4) m_mcr = d[4:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // update the modem-status model after a change settles
   task automatic settle_stat();
      logic [3:0] nv;
      repeat (6) @(negedge clk);
      nv = eff_of(m_mcr, ext);
      m_delta = m_delta | (m_eff ^ nv);
      m_eff = nv;
   endtask

   task automatic check_msr(input string req);
      logic [7:0] d;
      bus_read(3'd5, d);
      check(req, d, {m_eff, m_delta});
      m_delta = '0;
   endtask

   task automatic set_div(input logic [15:0] dv);
      bus_write(3'd3, 8'h80);
      bus_write(3'd0, dv[7:0]);
      bus_write(3'd1, dv[15:8]);
      bus_write(3'd3, 8'h00);
   endtask

   task automatic wait_lsr(input logic [7:0] mask);
      logic [7:0] d;
      d = '0;
      for (int i = 0; i < 20000 && (d & mask) != mask; i++) bus_read(3'd2, d);
   endtask

   task automatic ser_send(input logic [7:0] b, input bit good_stop, input int dv);
      logic [9:0] fr;
      fr = {1'b1, b, 1'b0};
      for (int i = 0; i < 9; i++) begin
         @(negedge clk); ser_rx = fr[i];
         repeat (16 * dv - 1) @(negedge clk);
      end
      @(negedge clk);
      ser_rx = good_stop;
      repeat (good_stop ? 16 * dv : 12 * dv) @(negedge clk);
      ser_rx = 1'b1;
      repeat (16 * dv) @(negedge clk);
   endtask

   task automatic measure_low(output int n);
      n = 0;
      @(negedge clk);
      while (ser_tx !== 1'b0) @(negedge clk);
      while (ser_tx === 1'b0) begin n++; @(negedge clk); end
   endtask

   initial begin
      logic [7:0] d;
      logic [9:0] got;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      bus_read(3'd2, d); check("R10 reset line status", d, 8'h06);
      bus_read(3'd4, d); check("R6 reset modem control", d, 8'h00);
      bus_read(3'd5, d); check("R8 reset modem status", d, 8'h00);
      check("R9 reset irq", irq, 1'b0);
      check("R3 idle line", ser_tx, 1'b1);

      // R1 latch access
      bus_write(3'd3, 8'h80);
      bus_write(3'd0, 8'h03);
      bus_write(3'd1, 8'h00);
      bus_read(3'd0, d); check("R1 divisor low readback", d, 8'h03);
      bus_read(3'd3, d); check("R1 line control readback", d, 8'h80);
      bus_write(3'd3, 8'h00);
      bus_read(3'd1, d); check("R1 ien not divisor", d, 8'h00);
      bus_read(3'd2, d); check("R1 latched write did not load holding", d[1], 1'b1);

      // R2 bit period for divisors 1, 2, 3 : start + 8 zero bits low
      for (int dv = 1; dv <= 3; dv++) begin
         set_div(16'(dv));
         wait_lsr(8'h04);
         bus_write(3'd0, 8'h00);
         measure_low(n);
         check("R2 low time", n, 144 * dv);
      end

      // R3 frame shape at divisor 1
      set_div(16'd1);
      wait_lsr(8'h04);
      bus_write(3'd0, 8'hA5);
      @(negedge clk);
      while (ser_tx !== 1'b0) @(negedge clk);
      got = '0;
      for (int idx = 0; idx < 160; idx++) begin
         if (idx % 16 == 8) got[idx / 16] = ser_tx;
         @(negedge clk);
      end
      check("R3 frame bits", got, {1'b1, 8'hA5, 1'b0});

      // R4 external receive at divisor 2
      set_div(16'd2);
      wait_lsr(8'h04);
      ser_send(8'h3C, 1'b1, 2);
      bus_read(3'd2, d); check("R4 data ready", d[0], 1'b1);
      check("R10 no framing error", d[3], 1'b0);
      bus_read(3'd0, d); check("R4 received byte", d, 8'h3C);
      bus_read(3'd2, d); check("R4 ready cleared by read", d[0], 1'b0);

      // R4 false start: 4 ticks low
      @(negedge clk); ser_rx = 1'b0;
      repeat (8) @(negedge clk);
      ser_rx = 1'b1;
      repeat (400) @(negedge clk);
      bus_read(3'd2, d); check("R4 false start ignored", d[0], 1'b0);

      // R10 framing error
      ser_send(8'hC3, 1'b0, 2);
      repeat (100) @(negedge clk);
      bus_read(3'd2, d); check("R10 framing flag", d[3], 1'b1);
      bus_read(3'd0, d); check("R10 byte with bad stop", d, 8'hC3);

      // external status pattern, outside loopback
      ext = 4'b0110;
      settle_stat();
      check_msr("R8 external change flags");
      check_msr("R8 flags cleared on read");

      // R6 pins follow control outside loopback
      bus_write(3'd4, 8'h0F);
      repeat (4) @(negedge clk);
      check("R6 pins driven", {out2_o, out1_o, rts_o, dtr_o}, 4'hF);

      // R5 loopback: rx pin at break, looped byte arrives
      bus_write(3'd4, 8'h10);
      settle_stat();
      check_msr("R7 loopback all off");
      ser_rx = 1'b0;
      repeat (400) @(negedge clk);
      bus_read(3'd2, d); check("R5 rx pin ignored", d[0], 1'b0);
      check("R5 tx pin high", ser_tx, 1'b1);
      bus_write(3'd1, 8'h01);
      check("R9 irq off before data", irq, 1'b0);
      bus_write(3'd0, 8'h5A);
      wait_lsr(8'h01);
      check("R9 rx irq in loopback", irq, 1'b1);
      bus_read(3'd0, d); check("R5 looped byte", d, 8'h5A);
      @(negedge clk);
      check("R9 rx irq cleared", irq, 1'b0);

      // R7 mapping one bit at a time, R9 modem irq
      bus_write(3'd1, 8'h04);
      bus_write(3'd4, 8'h12);
      settle_stat();
      check("R9 modem irq", irq, 1'b1);
      check_msr("R7 rts to cts");
      @(negedge clk);
      check("R9 modem irq cleared", irq, 1'b0);
      bus_write(3'd4, 8'h11); settle_stat(); check_msr("R7 dtr to dsr");
      bus_write(3'd4, 8'h14); settle_stat(); check_msr("R7 out1 to ri");
      bus_write(3'd4, 8'h18); settle_stat(); check_msr("R7 out2 to dcd");
      bus_write(3'd4, 8'h1F); settle_stat(); check_msr("R7 all on");

      // leave loopback with the line restored
      ser_rx = 1'b1;
      repeat (10) @(negedge clk);
      bus_write(3'd4, 8'h00);
      settle_stat();
      check_msr("R8 back to external");

      // R9 transmit-empty interrupt
      bus_write(3'd1, 8'h02);
      @(negedge clk);
      check("R9 tx empty irq", irq, 1'b1);
      bus_write(3'd1, 8'h00);
      @(negedge clk);
      check("R9 all disabled", irq, 1'b0);

      // R2 zero divisor: nothing leaves
      set_div(16'd0);
      bus_write(3'd0, 8'h00);
      repeat (300) @(negedge clk);
      bus_read(3'd2, d); check("R2 zero divisor holds frame", d[1], 1'b0);
      check("R2 zero divisor line idle", ser_tx, 1'b1);

      finish_run();
   end

endmodule